// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a memory device. It runs the sixteen-state test controller from a dedicated test clock, steered only by the mode-select input, and routes a serial path from the test data input to the test data output through either a 3-bit instruction register or one of three data registers. The data registers are a one-bit bypass stage, a 32-bit identification word and a boundary register of parameterised length that wraps the memory's data pins.

Every test input is taken on the rising test clock edge. The serial output and its drive enable change only on the falling edge, so the next device in a chain samples a settled value. While the external-test instruction is active, the block raises a high-impedance control that turns off all data pin drivers. The surrounding chip uses this together with the boundary update outputs.

Top module: `scan_tap`

## Requirements
- R1: While `trst_n` is low, the controller is held in Test-Logic-Reset, the active instruction is IDCODE, `tdo_oe` is 0, `pin_hiz` is 0 and `pin_out` is all zeros. Asserting `trst_n` takes effect without waiting for a clock edge.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state. Passing through that state makes IDCODE (001) the active instruction.
- R3: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 exactly while the controller is in Shift-DR or Shift-IR, and `tdo` is 0 whenever `tdo_oe` is 0.
- R4: In Capture-IR the instruction shift register loads binary 001. It shifts out least significant bit first, with `tdi` entering at bit 2. The shifted code becomes the active instruction on the rising edge that leaves Update-IR, and not before.
- R5: Code 001 (IDCODE) selects a 32-bit identification register. In Capture-DR it loads the `ID_CODE` parameter with bit 0 forced to 1, and it shifts out least significant bit first.
- R6: Code 111 (BYPASS) and the unused codes 010, 011, 101 and 110 select a one-bit register that captures 0. Data on `tdi` therefore reappears on `tdo` one shift later.
- R7: Code 100 (SAMPLE/PRELOAD) selects the boundary register. In Capture-DR it loads `pin_in`, with bit 0 shifted out first and `tdi` entering at the top bit. On leaving Update-DR it copies the shifted value to `pin_out`. `pin_hiz` stays 0 under this code.
- R8: Code 000 (EXTEST) selects the boundary register with the same capture, shift and update behaviour as R7. `pin_hiz` is 1 for as long as EXTEST is the active instruction.
- R9: `pin_out` changes only on leaving Update-DR while EXTEST or SAMPLE/PRELOAD is active. Data scans under any other instruction leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial test data in |
| pin_in | input | BSR_LEN | Values observed at the data pins, captured by the boundary register |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo`, high only in shift states |
| pin_out | output | BSR_LEN | Boundary update register contents for the pins |
| pin_hiz | output | 1 | Forces data pin drivers off while EXTEST is active |

## Verification
The bench targets the timing of instruction changes. It checks that `pin_hiz` is still low in Update-IR while EXTEST is being loaded, which catches a design that applies the shifted code early. It scans through every unused code and expects a one-bit path; a decoder that let an unused code fall through to the identification or boundary register would return far too long a delay. Random `tms` walks followed by five high cycles must always read the identification word back, which exposes a wrong arc in the state table or an instruction left unreset. The bench also asserts the asynchronous reset in the middle of a shift and scans the identification register with a parameter whose bit 0 is 0, so a missing forced bit 0 shows up.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {DR_BYPASS, DR_ID, DR_BOUND} dr_sel_e;

    function automatic dr_sel_e decode_dr(input logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST, OP_SAMPLE: return DR_BOUND;
            OP_IDCODE:            return DR_ID;
            default:              return DR_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q
);

    tap_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so
);

    typedef struct packed {
        logic [IR_W-1:0] shift;
        logic [IR_W-1:0] active;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_RESET:  r_d.active = OP_IDCODE;
            ST_CAP_IR: r_d.shift  = IR_CAPTURE;
            ST_SH_IR:  r_d.shift  = {tdi, r_q.shift[IR_W-1:1]};
            ST_UPD_IR: r_d.active = r_q.shift;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{shift: IR_CAPTURE, active: OP_IDCODE};
        else         r_q <= r_d;
    end

    assign ir_q  = r_q.active;
    assign ir_so = r_q.shift[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 8,
    parameter logic [31:0] ID_CODE = 32'h0000_0001
) (
    input  logic               tck,
    input  logic               trst_n,
    input  tap_state_e         state,
    input  logic               tdi,
    input  logic [IR_W-1:0]    op,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_so,
    output logic [BSR_LEN-1:0] pin_out
);

    localparam int          ID_W   = 32;
    localparam logic [31:0] ID_VAL = {ID_CODE[ID_W-1:1], 1'b1};

    typedef struct packed {
        logic               byp;
        logic [ID_W-1:0]    id;
        logic [BSR_LEN-1:0] bsr;
        logic [BSR_LEN-1:0] upd;
    } dr_regs_t;

    dr_regs_t r_d, r_q;
    dr_sel_e  sel;

    always_comb begin
        sel = decode_dr(op);
        r_d = r_q;
        case (state)
            ST_CAP_DR: begin
                case (sel)
                    DR_ID:    r_d.id  = ID_VAL;
                    DR_BOUND: r_d.bsr = pin_in;
                    default:  r_d.byp = 1'b0;
                endcase
            end
            ST_SH_DR: begin
                case (sel)
                    DR_ID:    r_d.id  = {tdi, r_q.id[ID_W-1:1]};
                    DR_BOUND: r_d.bsr = {tdi, r_q.bsr[BSR_LEN-1:1]};
                    default:  r_d.byp = tdi;
                endcase
            end
            ST_UPD_DR: if (sel == DR_BOUND) r_d.upd = r_q.bsr;
            default: ;
        endcase
        case (sel)
            DR_ID:    dr_so = r_q.id[0];
            DR_BOUND: dr_so = r_q.bsr[0];
            default:  dr_so = r_q.byp;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{byp: 1'b0, id: ID_VAL, bsr: '0, upd: '0};
        else         r_q <= r_d;
    end

    assign pin_out = r_q.upd;

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 8,
    parameter logic [31:0] ID_CODE = 32'h0000_0001
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] pin_out,
    output logic               pin_hiz
);

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_regs_t;

    tap_state_e      state_q;
    logic [IR_W-1:0] ir_q;
    logic            ir_so;
    logic            dr_so;
    out_regs_t       o_d, o_q;

    tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (state_q)
    );

    tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state_q),
        .tdi    (tdi),
        .ir_q   (ir_q),
        .ir_so  (ir_so)
    );

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .state   (state_q),
        .tdi     (tdi),
        .op      (ir_q),
        .pin_in  (pin_in),
        .dr_so   (dr_so),
        .pin_out (pin_out)
    );

    // Output stage on the falling edge: half a cycle of settling for the next device
    always_comb begin
        o_d.oe  = (state_q == ST_SH_DR) || (state_q == ST_SH_IR);
        o_d.tdo = o_d.oe && ((state_q == ST_SH_IR) ? ir_so : dr_so);
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '0;
        else         o_q <= o_d;
    end

    assign tdo     = o_q.tdo;
    assign tdo_oe  = o_q.oe;
    assign pin_hiz = (ir_q == OP_EXTEST);

endmodule

// File: rtl/tap_checker.sv
module tap_checker
    import tap_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input logic               tck,
    input logic               trst_n,
    input logic               tms,
    input logic               tdo,
    input logic               tdo_oe,
    input logic               pin_hiz,
    input logic [BSR_LEN-1:0] pin_out,
    input tap_state_e         state_q,
    input logic [IR_W-1:0]    ir_q
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)          ones_q <= '0;
        else if (!tms)        ones_q <= '0;
        else if (ones_q != 7) ones_q <= ones_q + 3'd1;
    end

    a_r2_five_high_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q >= 3'd5) |-> (state_q == ST_RESET));

    a_r3_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == ((state_q == ST_SH_DR) || (state_q == ST_SH_IR)));

    a_r3_tdo_quiet: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_oe |-> !tdo);

    a_r4_ir_changes_at_update: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(ir_q) |-> ($past(state_q) == ST_UPD_IR || $past(state_q) == ST_RESET));

    a_r8_hiz_after_update: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(pin_hiz) |-> $past(state_q) == ST_UPD_IR);

    a_r9_pin_out_hold: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(pin_out) |-> ($past(state_q) == ST_UPD_DR &&
                               ($past(ir_q) == OP_EXTEST || $past(ir_q) == OP_SAMPLE)));

endmodule

bind scan_tap tap_checker #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck     (tck),
    .trst_n  (trst_n),
    .tms     (tms),
    .tdo     (tdo),
    .tdo_oe  (tdo_oe),
    .pin_hiz (pin_hiz),
    .pin_out (pin_out),
    .state_q (state_q),
    .ir_q    (ir_q)
);

// File: tb/scan_tap_bench.sv
module scan_tap_bench;

    localparam int          BSR_LEN = 8;
    localparam logic [31:0] ID_PAR  = 32'h4F2A_6C18;
    localparam logic [31:0] ID_EXP  = 32'h4F2A_6C19;

    logic               tck = 1'b0;
    logic               trst_n = 1'b0;
    logic               tms = 1'b1;
    logic               tdi = 1'b0;
    logic [BSR_LEN-1:0] pin_in = '0;
    logic               tdo, tdo_oe, pin_hiz;
    logic [BSR_LEN-1:0] pin_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    scan_tap #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_PAR)) u_scan_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out), .pin_hiz(pin_hiz)
    );

    always #4 tck = ~tck;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One TCK cycle: drive, observe after the falling edge, pass the rising edge
    task automatic step(input logic m, input logic d, output logic so, output logic oe);
        tms = m;
        tdi = d;
        @(negedge tck);
        #1;
        so = tdo;
        oe = tdo_oe;
        @(posedge tck);
        #1;
    endtask

    task automatic go_idle();
        logic so, oe;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, so, oe);
        step(1'b0, 1'b0, so, oe);
    endtask

    // From Idle; returns captured bits, pin_hiz seen in Update-IR, oe errors
    task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap,
                           output logic hiz_upd, output int oe_bad);
        logic so, oe;
        oe_bad = 0;
        step(1'b1, 1'b0, so, oe);
        step(1'b1, 1'b0, so, oe);
        step(1'b0, 1'b0, so, oe);
        step(1'b0, 1'b0, so, oe);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, op[i], so, oe);
            cap[i] = so;
            if (!oe) oe_bad++;
        end
        step(1'b1, 1'b0, so, oe);
        if (oe) oe_bad++;
        hiz_upd = pin_hiz;
        step(1'b0, 1'b0, so, oe);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din,
                           output logic [63:0] dout, output int oe_bad);
        logic so, oe;
        oe_bad = 0;
        dout = '0;
        step(1'b1, 1'b0, so, oe);
        step(1'b0, 1'b0, so, oe);
        step(1'b0, 1'b0, so, oe);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], so, oe);
            dout[i] = so;
            if (!oe) oe_bad++;
        end
        step(1'b1, 1'b0, so, oe);
        if (oe) oe_bad++;
        step(1'b0, 1'b0, so, oe);
    endtask

    function automatic logic [63:0] bypass_exp(input int n, input logic [63:0] din);
        logic [63:0] r = '0;
        for (int i = 1; i < n; i++) r[i] = din[i-1];
        return r;
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0]  cap;
        logic        hiz;
        logic [63:0] dout, pat;
        logic [BSR_LEN-1:0] keep;
        logic        so, oe;
        int          bad;
        logic [2:0]  unused_ops [4];
        void'($urandom(32'd1234));
        unused_ops = '{3'b010, 3'b011, 3'b101, 3'b110};

        // R1: state under reset
        #20;
        chk("R1 oe in reset", {63'd0, tdo_oe}, 64'd0);
        chk("R1 hiz in reset", {63'd0, pin_hiz}, 64'd0);
        chk("R1 pin_out in reset", {56'd0, pin_out}, 64'd0);
        @(posedge tck); #1;
        trst_n = 1'b1;
        step(1'b0, 1'b0, so, oe);   // to Idle
        chk("R3 oe low in Idle", {63'd0, oe}, 64'd0);

        // R5: identification word right after reset, bit 0 forced
        scan_dr(32, 64'hFFFF_FFFF, dout, bad);
        chk("R5 idcode after reset", dout, {32'd0, ID_EXP});
        chk("R3 oe only in Shift-DR", bad, 0);

        // R4: capture pattern and late instruction update
        scan_ir(3'b111, cap, hiz, bad);
        chk("R4 IR capture value", {61'd0, cap}, 64'd1);
        chk("R3 oe only in Shift-IR", bad, 0);

        // R6: bypass path
        pat = 64'h00A5;
        scan_dr(8, pat, dout, bad);
        chk("R6 bypass 111", dout, bypass_exp(8, pat));
        foreach (unused_ops[k]) begin
            scan_ir(unused_ops[k], cap, hiz, bad);
            pat = {32'd0, $urandom} & 64'h3FF;
            scan_dr(10, pat, dout, bad);
            chk("R6 unused code is bypass", dout, bypass_exp(10, pat));
        end

        // R7: sample/preload
        scan_ir(3'b100, cap, hiz, bad);
        chk("R7 hiz low under SAMPLE", {63'd0, pin_hiz}, 64'd0);
        pin_in = 8'h3C;
        pat = 64'h00C9;
        scan_dr(BSR_LEN, pat, dout, bad);
        chk("R7 sample capture", dout, 64'h3C);
        chk("R7 preload to pin_out", {56'd0, pin_out}, pat);

        // R8 and R4: EXTEST timing
        scan_ir(3'b000, cap, hiz, bad);
        chk("R4 hiz not yet set in Update-IR", {63'd0, hiz}, 64'd0);
        chk("R8 hiz under EXTEST", {63'd0, pin_hiz}, 64'd1);
        for (int t = 0; t < 3; t++) begin
            pin_in = BSR_LEN'($urandom);
            pat = {56'd0, 8'($urandom)};
            scan_dr(BSR_LEN, pat, dout, bad);
            chk("R8 extest capture", dout, {56'd0, pin_in});
            chk("R8 extest update", {56'd0, pin_out}, pat);
        end

        // R9: pin_out held under other instructions
        keep = pin_out;
        scan_ir(3'b001, cap, hiz, bad);
        chk("R8 hiz released", {63'd0, pin_hiz}, 64'd0);
        scan_dr(32, 64'h1234_5678, dout, bad);
        chk("R5 idcode reloaded", dout, {32'd0, ID_EXP});
        chk("R9 pin_out held after ID scan", {56'd0, pin_out}, {56'd0, keep});
        scan_ir(3'b111, cap, hiz, bad);
        scan_dr(8, 64'hFF, dout, bad);
        chk("R9 pin_out held after bypass scan", {56'd0, pin_out}, {56'd0, keep});

        // R2: random walks then five TMS highs
        for (int w = 0; w < 6; w++) begin
            scan_ir(3'b111, cap, hiz, bad);
            for (int s = 0; s < 25; s++) step(1'($urandom), 1'($urandom), so, oe);
            for (int s = 0; s < 5; s++) step(1'b1, 1'b0, so, oe);
            step(1'b0, 1'b0, so, oe);
            chk("R2 oe low after reset walk", {63'd0, oe}, 64'd0);
            scan_dr(32, 64'd0, dout, bad);
            chk("R2 IDCODE after five TMS highs", dout, {32'd0, ID_EXP});
        end

        // R1: asynchronous reset in the middle of a shift
        scan_ir(3'b111, cap, hiz, bad);
        step(1'b1, 1'b0, so, oe);
        step(1'b0, 1'b0, so, oe);
        step(1'b0, 1'b0, so, oe);
        step(1'b0, 1'b1, so, oe);
        chk("R3 oe high in Shift-DR", {63'd0, oe}, 64'd1);
        #1;
        trst_n = 1'b0;
        #1;
        chk("R1 async reset drops oe", {63'd0, tdo_oe}, 64'd0);
        @(posedge tck); #1;
        trst_n = 1'b1;
        step(1'b0, 1'b0, so, oe);
        scan_dr(32, 64'd0, dout, bad);
        chk("R1 IDCODE after async reset", dout, {32'd0, ID_EXP});

        go_idle();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule